// File: doc/BRIEF.md
# Separable Elliptical Kernel Weight Generator

This block produces spatial weights for an elliptical target window. The weights have an Epanechnikov profile: 1.0 at the window centre, falling with the normalized squared distance and clipped to zero outside the ellipse. The block never evaluates a two-dimensional formula per pixel. A start strobe latches the window width and height. A sequential controller then computes one reciprocal bandwidth per axis with a shared bit-serial divider. It then fills two one-dimensional tables, one entry per column and one per row, with the normalized squared offset of that column or row. A single shared multiplier is used for all of this work.

After generation completes, a lookup port accepts a column and row and returns the weight one cycle later. The lookup uses only an adder and a comparator on the two table entries. A lookup issued before the tables are complete is answered with an error flag and a zero weight. A pixel tracker uses the weights to build kernel-weighted colour histograms.

Top module: `sep_kernel_gen`

## Requirements
- R1: After reset, busy, done, ready and wt_valid are all low.
- R2: A start pulse with busy low captures win_w and win_h, each in the range 2 to 64. busy is high from the next cycle until generation ends. At the end, done pulses high for exactly one cycle, busy falls and ready rises in that same cycle.
- R3: A start pulse while busy is high has no effect. Generation finishes with the dimensions captured first.
- R4: For a dimension D, let a = floor(D/2) and r = floor(2^32 / a^2). The table entry for index i holds floor((i-a)^2 * r / 2^16) as an unsigned Q16.16 value.
- R5: Inside the window, the weight is 65536 - t when t <= 65536 and 0 otherwise, where t is the column entry plus the row entry. Weights are unsigned Q16.16, with 65536 meaning 1.0.
- R6: The weight at column floor(win_w/2), row floor(win_h/2) is exactly 65536.
- R7: A lookup with lk_x >= win_w or lk_y >= win_h returns weight 0 with wt_err low.
- R8: A lookup while ready is low returns wt_err high and weight 0.
- R9: wt_valid is high exactly in the cycle after a cycle with lk_req high.
- R10: done arrives no fewer than 2(win_w+win_h) cycles and no more than 2(win_w+win_h)+72 cycles after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin generation for the given window |
| win_w | input | 7 | Window width in pixels, 2 to 64 |
| win_h | input | 7 | Window height in pixels, 2 to 64 |
| busy | output | 1 | Tables are being generated |
| done | output | 1 | One-cycle pulse when generation ends |
| ready | output | 1 | Tables hold a complete kernel |
| lk_req | input | 1 | Lookup request |
| lk_x | input | 6 | Lookup column |
| lk_y | input | 6 | Lookup row |
| wt_valid | output | 1 | Lookup result valid |
| wt_err | output | 1 | Lookup was made without complete tables |
| weight | output | 32 | Kernel weight, unsigned Q16.16 |

## Verification
The assertions take for granted that a start accepted while idle carries both dimensions between 2 and 64. A one-pixel axis would give a zero bandwidth and a divide by zero, so a property also checks that this input assumption holds. The bench only ever applies dimensions inside that range, including the smallest window of 2 by 2 and the largest of 64 by 64. Stray starts during generation carry the largest dimensions, so an accepted stray start would be visible in the swept weights. Each sweep covers every column and row the lookup port can address, so the out-of-window cases are exercised at every boundary.

// File: rtl/sep_kgen_pkg.sv
package sep_kgen_pkg;

    localparam int KG_MAX_DIM = 64;
    localparam int KG_FRAC    = 16;
    localparam int KG_DATA_W  = 32;
    localparam int KG_IDX_W   = $clog2(KG_MAX_DIM);
    localparam int KG_DIM_W   = KG_IDX_W + 1;
    localparam int KG_SQ_W    = 2 * KG_IDX_W;
    localparam int KG_RCP_W   = 2 * KG_FRAC + 1;

    typedef enum logic [2:0] {
        KG_IDLE  = 3'd0,
        KG_BW    = 3'd1,
        KG_DWAIT = 3'd2,
        KG_SQ    = 3'd3,
        KG_SC    = 3'd4
    } kg_state_e;

    function automatic logic [KG_IDX_W-1:0] kg_abs_off(
        input logic [KG_IDX_W-1:0] idx,
        input logic [KG_IDX_W-1:0] mid
    );
        return (idx >= mid) ? (idx - mid) : (mid - idx);
    endfunction

endpackage

// File: rtl/kgen_mul.sv
module kgen_mul #(
    parameter int A_W = 33,
    parameter int B_W = 12,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);
    always_comb begin
        p = P_W'(a) * P_W'(b);
    end
endmodule

// File: rtl/kgen_div.sv
module kgen_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 12,
    localparam int CNT_W = $clog2(NUM_W),
    localparam logic [NUM_W-1:0] NUMER = NUM_W'(1) << (NUM_W - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);
    logic [DEN_W-1:0] den_q, rem_q;
    logic [NUM_W-1:0] dvd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   shifted, trial;
    logic             fits;

    always_comb begin
        shifted = {rem_q, dvd_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den_q};
        trial   = fits ? (shifted - {1'b0, den_q}) : shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            den_q <= '0;
            rem_q <= '0;
            dvd_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                den_q <= den;
                rem_q <= '0;
                dvd_q <= NUMER;
                cnt_q <= CNT_W'(NUM_W - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= trial[DEN_W-1:0];
                dvd_q <= {dvd_q[NUM_W-2:0], fits};
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assign quo = dvd_q;
endmodule

// File: rtl/kgen_tab.sv
module kgen_tab #(
    parameter int MAX_DIM = 64,
    parameter int DATA_W  = 32,
    localparam int DEPTH  = 2 * MAX_DIM,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr [2],
    output logic [DATA_W-1:0] rd_data [2]
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    for (genvar g = 0; g < 2; g++) begin : g_rd
        assign rd_data[g] = mem[rd_addr[g]];
    end
endmodule

// File: rtl/kgen_look.sv
module kgen_look #(
    parameter int DATA_W = 32,
    parameter int FRAC   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              tab_ok,
    input  logic              in_win,
    input  logic [DATA_W-1:0] kx,
    input  logic [DATA_W-1:0] ky,
    output logic              wt_valid,
    output logic              wt_err,
    output logic [DATA_W-1:0] weight
);
    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] w;
    } look_res_t;

    localparam logic [DATA_W:0] ONE = (DATA_W+1)'(1) << FRAC;

    look_res_t res_n, res_q;
    logic [DATA_W:0] t_sum;

    always_comb begin
        t_sum     = {1'b0, kx} + {1'b0, ky};
        res_n.vld = req;
        res_n.err = req & ~tab_ok;
        if (!tab_ok || !in_win || t_sum > ONE) res_n.w = '0;
        else                                   res_n.w = DATA_W'(ONE - t_sum);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_n;
    end

    assign wt_valid = res_q.vld;
    assign wt_err   = res_q.err;
    assign weight   = res_q.w;
endmodule

// File: rtl/kgen_ctrl.sv
module kgen_ctrl
    import sep_kgen_pkg::*;
#(
    parameter int IDX_W  = KG_IDX_W,
    parameter int DATA_W = KG_DATA_W,
    parameter int FRAC   = KG_FRAC,
    localparam int DIM_W = IDX_W + 1,
    localparam int SQ_W  = 2 * IDX_W,
    localparam int RCP_W = 2 * FRAC + 1,
    localparam int P_W   = RCP_W + SQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  win_w,
    input  logic [DIM_W-1:0]  win_h,
    output logic              busy,
    output logic              done,
    output logic              ready,
    output logic [DIM_W-1:0]  win_w_q,
    output logic [DIM_W-1:0]  win_h_q,
    output logic [RCP_W-1:0]  mul_a,
    output logic [SQ_W-1:0]   mul_b,
    input  logic [P_W-1:0]    mul_p,
    output logic              div_start,
    output logic [SQ_W-1:0]   div_den,
    input  logic [RCP_W-1:0]  div_quo,
    input  logic              div_done,
    output logic              wr_en,
    output logic [IDX_W:0]    wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    kg_state_e        state_q;
    logic             ax_q;
    logic [IDX_W-1:0] idx_q;
    logic [SQ_W-1:0]  sq_q;
    logic [RCP_W-1:0] rcp_q [2];
    logic [DIM_W-1:0] dim_cur;
    logic [IDX_W-1:0] half, off;
    logic             last;

    always_comb begin
        dim_cur = ax_q ? win_h_q : win_w_q;
        half    = IDX_W'(dim_cur >> 1);
        off     = kg_abs_off(idx_q, half);
        last    = (DIM_W'(idx_q) == (dim_cur - DIM_W'(1)));
        mul_a   = '0;
        mul_b   = '0;
        case (state_q)
            KG_BW: begin
                mul_a = RCP_W'(half);
                mul_b = SQ_W'(half);
            end
            KG_SQ: begin
                mul_a = RCP_W'(off);
                mul_b = SQ_W'(off);
            end
            KG_SC: begin
                mul_a = rcp_q[ax_q];
                mul_b = sq_q;
            end
            default: ;
        endcase
        div_start = (state_q == KG_BW);
        div_den   = mul_p[SQ_W-1:0];
        wr_en     = (state_q == KG_SC);
        wr_addr   = {ax_q, idx_q};
        wr_data   = DATA_W'(mul_p >> FRAC);
        busy      = (state_q != KG_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= KG_IDLE;
            ax_q     <= 1'b0;
            idx_q    <= '0;
            sq_q     <= '0;
            rcp_q[0] <= '0;
            rcp_q[1] <= '0;
            win_w_q  <= '0;
            win_h_q  <= '0;
            done     <= 1'b0;
            ready    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                KG_IDLE: if (start) begin
                    win_w_q <= win_w;
                    win_h_q <= win_h;
                    ax_q    <= 1'b0;
                    ready   <= 1'b0;
                    state_q <= KG_BW;
                end
                KG_BW: state_q <= KG_DWAIT;
                KG_DWAIT: if (div_done) begin
                    rcp_q[ax_q] <= div_quo;
                    idx_q       <= '0;
                    if (!ax_q) begin
                        ax_q    <= 1'b1;
                        state_q <= KG_BW;
                    end else begin
                        ax_q    <= 1'b0;
                        state_q <= KG_SQ;
                    end
                end
                KG_SQ: begin
                    sq_q    <= mul_p[SQ_W-1:0];
                    state_q <= KG_SC;
                end
                KG_SC: begin
                    state_q <= KG_SQ;
                    if (!last) begin
                        idx_q <= idx_q + IDX_W'(1);
                    end else if (!ax_q) begin
                        ax_q  <= 1'b1;
                        idx_q <= '0;
                    end else begin
                        state_q <= KG_IDLE;
                        done    <= 1'b1;
                        ready   <= 1'b1;
                    end
                end
                default: state_q <= KG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sep_kernel_gen.sv
module sep_kernel_gen
    import sep_kgen_pkg::*;
#(
    parameter int MAX_DIM = KG_MAX_DIM,
    parameter int FRAC    = KG_FRAC,
    parameter int DATA_W  = KG_DATA_W,
    localparam int IDX_W  = $clog2(MAX_DIM),
    localparam int DIM_W  = IDX_W + 1,
    localparam int SQ_W   = 2 * IDX_W,
    localparam int RCP_W  = 2 * FRAC + 1,
    localparam int P_W    = RCP_W + SQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  win_w,
    input  logic [DIM_W-1:0]  win_h,
    output logic              busy,
    output logic              done,
    output logic              ready,
    input  logic              lk_req,
    input  logic [IDX_W-1:0]  lk_x,
    input  logic [IDX_W-1:0]  lk_y,
    output logic              wt_valid,
    output logic              wt_err,
    output logic [DATA_W-1:0] weight
);
    logic [DIM_W-1:0]  win_w_q, win_h_q;
    logic [RCP_W-1:0]  mul_a, div_quo;
    logic [SQ_W-1:0]   mul_b, div_den;
    logic [P_W-1:0]    mul_p;
    logic              div_start, div_done, wr_en, in_win;
    logic [IDX_W:0]    wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [IDX_W:0]    rd_addr [2];
    logic [DATA_W-1:0] rd_data [2];

    kgen_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .FRAC(FRAC)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .win_w(win_w), .win_h(win_h),
        .busy(busy), .done(done), .ready(ready),
        .win_w_q(win_w_q), .win_h_q(win_h_q),
        .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
        .div_start(div_start), .div_den(div_den), .div_quo(div_quo), .div_done(div_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    kgen_mul #(.A_W(RCP_W), .B_W(SQ_W)) u_mul (.a(mul_a), .b(mul_b), .p(mul_p));

    kgen_div #(.NUM_W(RCP_W), .DEN_W(SQ_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .den(div_den),
        .quo(div_quo), .done(div_done)
    );

    assign rd_addr[0] = {1'b0, lk_x};
    assign rd_addr[1] = {1'b1, lk_y};
    assign in_win     = (DIM_W'(lk_x) < win_w_q) && (DIM_W'(lk_y) < win_h_q);

    kgen_tab #(.MAX_DIM(MAX_DIM), .DATA_W(DATA_W)) u_tab (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    kgen_look #(.DATA_W(DATA_W), .FRAC(FRAC)) u_look (
        .clk(clk), .rst(rst), .req(lk_req), .tab_ok(ready), .in_win(in_win),
        .kx(rd_data[0]), .ky(rd_data[1]),
        .wt_valid(wt_valid), .wt_err(wt_err), .weight(weight)
    );
endmodule

// File: rtl/sep_kernel_gen_chk.sv
module sep_kernel_gen_chk
    import sep_kgen_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [KG_DIM_W-1:0]  win_w,
    input logic [KG_DIM_W-1:0]  win_h,
    input logic                 busy,
    input logic                 done,
    input logic                 ready,
    input logic                 lk_req,
    input logic [KG_IDX_W-1:0]  lk_x,
    input logic [KG_IDX_W-1:0]  lk_y,
    input logic                 wt_valid,
    input logic                 wt_err,
    input logic [KG_DATA_W-1:0] weight,
    input logic [KG_DIM_W-1:0]  win_w_q,
    input logic [KG_DIM_W-1:0]  win_h_q
);
    localparam logic [KG_DATA_W-1:0] ONE  = KG_DATA_W'(1) << KG_FRAC;
    localparam logic [KG_DIM_W-1:0]  DMAX = KG_DIM_W'(KG_MAX_DIM);
    localparam logic [KG_DIM_W-1:0]  DMIN = KG_DIM_W'(2);

    // R2
    dims_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> (win_w >= DMIN && win_w <= DMAX && win_h >= DMIN && win_h <= DMAX));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R2
    done_ready_chk: assert property (@(posedge clk) disable iff (rst) done |-> (ready && !busy));
    // R2
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && ready));
    // R3
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(win_w_q) && $stable(win_h_q)));
    // R9
    look_lat_chk: assert property (@(posedge clk) disable iff (rst) lk_req |=> wt_valid);
    // R9
    look_idle_chk: assert property (@(posedge clk) disable iff (rst) !lk_req |=> !wt_valid);
    // R8
    stale_look_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !ready) |=> (wt_err && weight == '0));
    // R5
    weight_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        wt_valid |-> (weight <= ONE));
    // R7
    outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && ready && (KG_DIM_W'(lk_x) >= win_w_q || KG_DIM_W'(lk_y) >= win_h_q))
        |=> (weight == '0 && !wt_err));
endmodule

bind sep_kernel_gen sep_kernel_gen_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .win_w(win_w), .win_h(win_h),
    .busy(busy), .done(done), .ready(ready), .lk_req(lk_req), .lk_x(lk_x), .lk_y(lk_y),
    .wt_valid(wt_valid), .wt_err(wt_err), .weight(weight),
    .win_w_q(win_w_q), .win_h_q(win_h_q)
);

// File: tb/sep_kernel_gen_bench.sv
module sep_kernel_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  win_w = '0, win_h = '0;
    logic        busy, done, ready;
    logic        lk_req = 1'b0;
    logic [5:0]  lk_x = '0, lk_y = '0;
    logic        wt_valid, wt_err;
    logic [31:0] weight;
    int          errs = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    sep_kernel_gen u_sep_kernel_gen (
        .clk(clk), .rst(rst), .start(start), .win_w(win_w), .win_h(win_h),
        .busy(busy), .done(done), .ready(ready),
        .lk_req(lk_req), .lk_x(lk_x), .lk_y(lk_y),
        .wt_valid(wt_valid), .wt_err(wt_err), .weight(weight)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint axis_val(input int d, input int i);
        longint a, r, dx;
        a  = d / 2;
        r  = (64'd1 << 32) / (a * a);
        dx = i - a;
        return (dx * dx * r) >> 16;
    endfunction

    function automatic longint exp_weight(input int w, input int h, input int x, input int y);
        longint t;
        if (x >= w || y >= h) return 0;
        t = axis_val(w, x) + axis_val(h, y);
        return (t <= 65536) ? 65536 - t : 0;
    endfunction

    task automatic lookup(input int x, input int y);
        lk_req = 1'b1;
        lk_x   = 6'(x);
        lk_y   = 6'(y);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic gen(input int w, input int h, input bit poke);
        int cyc;
        int lo, hi;
        start = 1'b1;
        win_w = 7'(w);
        win_h = 7'(h);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        if (poke) begin
            start = 1'b1;
            win_w = 7'd64;
            win_h = 7'd64;
            lookup(0, 0);
            start = 1'b0;
            cyc++;
            chk(wt_err == 1'b1 && weight == 0, "R8 lookup while busy", longint'(wt_err), 1);
        end
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        lo = 2 * (w + h);
        hi = 2 * (w + h) + 72;
        chk(cyc >= lo && cyc <= hi, "R10 generation time", cyc, hi);
        chk(ready == 1'b1 && busy == 1'b0, "R2 ready with done", longint'(ready), 1);
        @(negedge clk);
        chk(done == 1'b0, "R2 done single pulse", longint'(done), 0);
    endtask

    task automatic sweep(input int w, input int h);
        longint e;
        for (int y = 0; y < 64; y++) begin
            for (int x = 0; x < 64; x++) begin
                lookup(x, y);
                e = exp_weight(w, h, x, y);
                if (!wt_valid) chk(1'b0, "R9 valid after request", 0, 1);
                if (x >= w || y >= h)
                    chk(weight == 32'(e) && !wt_err, "R7 outside window", weight, e);
                else if (x == w / 2 && y == h / 2)
                    chk(weight == 32'd65536, "R6 centre weight", weight, 65536);
                else if (x == w / 2 || y == h / 2)
                    chk(weight == 32'(e), "R4 axis entry", weight, e);
                else
                    chk(weight == 32'(e), "R5 combined weight", weight, e);
            end
        end
        @(negedge clk);
        chk(wt_valid == 1'b0, "R9 no request no valid", longint'(wt_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !ready && !wt_valid, "R1 reset state",
            longint'({busy, done, ready, wt_valid}), 0);
        lookup(3, 3);
        chk(wt_valid && wt_err && weight == 0, "R8 lookup before generation", longint'(wt_err), 1);
        gen(8, 6, 1'b1);
        sweep(8, 6);          // R3: stray 64x64 start must not have taken effect
        gen(64, 64, 1'b0);
        sweep(64, 64);
        gen(5, 9, 1'b0);
        sweep(5, 9);
        gen(2, 2, 1'b0);
        sweep(2, 2);
        gen(33, 17, 1'b1);
        sweep(33, 17);        // R3 again with odd sizes
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule